// File: doc/BRIEF.md
# Staged Memory Access Interface

This block connects a processing core to a word-addressed synchronous memory. Each access runs through two staging registers: an address register that feeds the memory address port, and a data register that feeds the memory write-data port and also returns load results to the core. The core raises a request with an operation select (load or store), an address and, for stores, a write word. The interface accepts the request only when it is idle, holds the request, and then steps through a fixed sequence of register loads and one strobe.

A load places the address in the address register, pulses the read strobe, and captures the memory's reply into the data register. The memory has one cycle of read latency. A store places the write word in the data register first, then the address in the address register, and then pulses the write strobe. Both operations finish with a one-cycle done pulse in the same cycle position after acceptance, so the core sees a fixed latency of four cycles. Requests that arrive while an access is in flight are dropped.

Top module: `stg_mem_if`

## Requirements
- R1: While rst_ni is low and after its release, the address register (mem_addr_o) and data register (mem_wdata_o, rdata_o) are zero, and mem_rd_o, mem_wr_o, busy_o and done_o are low.
- R2: A request (req_i high at a rising edge) is accepted only when busy_o is low. A request while busy_o is high, including in the done cycle, has no effect: no extra strobe follows and neither staging register changes.
- R3: Load order, with cycle k being the k-th cycle after the accepting edge: in cycle 1 mem_addr_o still holds its old value; in cycle 2 mem_addr_o equals the request address and mem_rd_o is high; in cycle 4 rdata_o holds the memory word at that address.
- R4: Store order: in cycle 1 both staging registers hold their old values; in cycle 2 mem_wdata_o equals the write word while mem_addr_o is still old; in cycle 3 mem_addr_o equals the request address, mem_wdata_o is unchanged and mem_wr_o is high.
- R5: mem_rd_o and mem_wr_o are never high together, and each is high for exactly one cycle per access of its kind and never for the other kind.
- R6: done_o is high for exactly one cycle, in cycle 4, for both loads and stores; it follows the write strobe by one cycle.
- R7: busy_o is high from cycle 1 through the done cycle and low in cycle 5; while busy_o is low no strobe or done is active.
- R8: The data register loads mem_rdata_i as it stands in the cycle after the read strobe.
- R9: After a store, rdata_o shows the written word from cycle 2 until the next access changes the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Store word |
| busy_o | output | 1 | Access in flight |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Data register contents |
| mem_addr_o | output | ADDR_W | Address register to memory |
| mem_wdata_o | output | DATA_W | Data register to memory |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_rdata_i | input | DATA_W | Memory read word, one cycle after mem_rd_o |

## Verification
The completion pulse of one access and the arrival of the next request can meet in the same cycle; because the done cycle still counts as busy, that request must be dropped. The bench provokes this by holding a conflicting store request high from cycle 1 through the done cycle of an access, then releasing it, and judges the outcome at the ports: the access in progress must follow its normal sequence, no strobe may appear in the idle cycles after it, the address register must keep the old address, and a later load of the conflicting store's address must return the unmodified word.

// File: rtl/smi_pkg.sv
package smi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LD_MAR,
    ST_LD_RD,
    ST_LD_CAP,
    ST_WR_MDR,
    ST_WR_MAR,
    ST_WR_STB,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic mar_ld;     // address register <- held request address
    logic mdr_ld_wr;  // data register <- held write word
    logic mdr_ld_rd;  // data register <- memory read word
  } stage_ctl_t;

endpackage

// File: rtl/smi_req_latch.sv
module smi_req_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              idle_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              accept_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] wdata_q_o
);

  assign accept_o = req_i & idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o  <= '0;
      wdata_q_o <= '0;
    end else if (accept_o) begin
      addr_q_o  <= addr_i;
      wdata_q_o <= wdata_i;
    end
  end

  // held request must not move while an access is in flight
  p_hold_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(addr_q_o) && $stable(wdata_q_o));

endmodule

// File: rtl/smi_seq.sv
module smi_seq
  import smi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       we_i,
  output logic       idle_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       rd_o,
  output logic       wr_o,
  output stage_ctl_t ctl_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_i) state_d = we_i ? ST_WR_MDR : ST_LD_MAR;
      ST_LD_MAR: state_d = ST_LD_RD;
      ST_LD_RD:  state_d = ST_LD_CAP;
      ST_LD_CAP: state_d = ST_DONE;
      ST_WR_MDR: state_d = ST_WR_MAR;
      ST_WR_MAR: state_d = ST_WR_STB;
      ST_WR_STB: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o = (state_q == ST_IDLE);
  assign busy_o = ~idle_o;
  assign done_o = (state_q == ST_DONE);
  assign rd_o   = (state_q == ST_LD_RD);
  assign wr_o   = (state_q == ST_WR_STB);

  always_comb begin
    ctl_o           = '0;
    ctl_o.mar_ld    = (state_q == ST_LD_MAR) || (state_q == ST_WR_MAR);
    ctl_o.mdr_ld_wr = (state_q == ST_WR_MDR);
    ctl_o.mdr_ld_rd = (state_q == ST_LD_CAP);
  end

  // read strobe is always followed by the capture step
  p_rd_then_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> ctl_o.mdr_ld_rd);

  // address is staged in the cycle before either strobe
  p_mar_before_stb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.mar_ld |=> (rd_o || wr_o));

endmodule

// File: rtl/smi_stage_regs.sv
module smi_stage_regs
  import smi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stage_ctl_t        ctl_i,
  input  logic [ADDR_W-1:0] addr_q_i,
  input  logic [DATA_W-1:0] wdata_q_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           mar_o <= '0;
    else if (ctl_i.mar_ld) mar_o <= addr_q_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mdr_o <= '0;
    else if (ctl_i.mdr_ld_wr) mdr_o <= wdata_q_i;
    else if (ctl_i.mdr_ld_rd) mdr_o <= mem_rdata_i;
  end

  p_mdr_src_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_i.mdr_ld_wr && ctl_i.mdr_ld_rd));

endmodule

// File: rtl/stg_mem_if.sv
module stg_mem_if
  import smi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  logic              idle, accept;
  logic [ADDR_W-1:0] addr_q, mar;
  logic [DATA_W-1:0] wdata_q, mdr;
  stage_ctl_t        ctl;

  smi_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .idle_i    (idle),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .accept_o  (accept),
    .addr_q_o  (addr_q),
    .wdata_q_o (wdata_q)
  );

  smi_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .we_i     (we_i),
    .idle_o   (idle),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .ctl_o    (ctl)
  );

  smi_stage_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl),
    .addr_q_i    (addr_q),
    .wdata_q_i   (wdata_q),
    .mem_rdata_i (mem_rdata_i),
    .mar_o       (mar),
    .mdr_o       (mdr)
  );

  assign mem_addr_o  = mar;
  assign mem_wdata_o = mdr;
  assign rdata_o     = mdr;

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_rd_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  p_wr_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o);

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_wr_then_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> done_o);

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_rd_o && !mem_wr_o && !done_o));

  p_done_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_cap_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> ##1 (rdata_o == $past(mem_rdata_i)));

  p_wdata_staged_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $stable(mem_wdata_o));

endmodule

// File: tb/stg_mem_if_tb.sv
module stg_mem_if_tb;

  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          busy_o, done_o, mem_rd_o, mem_wr_o;
  logic [DW-1:0] rdata_o, mem_wdata_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_rdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  stg_mem_if #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .we_i        (we),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_rdata_i (mem_rdata)
  );

  function automatic logic [DW-1:0] seed_word(input logic [7:0] a);
    return (DW'(a) * 16'h2f1b) ^ 16'hc3a5;
  endfunction

  // memory model: 256 words indexed by the low address byte, one-cycle read latency
  logic [DW-1:0] bmem [256];
  logic [255:0]  bwr = '0;
  always @(posedge clk) begin
    if (mem_wr_o) begin
      bmem[mem_addr_o[7:0]] <= mem_wdata_o;
      bwr[mem_addr_o[7:0]]  <= 1'b1;
    end
    if (mem_rd_o)
      mem_rdata <= bwr[mem_addr_o[7:0]] ? bmem[mem_addr_o[7:0]] : seed_word(mem_addr_o[7:0]);
  end

  // bench-side expectations
  logic [DW-1:0] exp_mem [256];
  logic [255:0]  exp_wr = '0;
  logic [AW-1:0] mar_m = '0;
  logic [DW-1:0] mdr_m = '0;

  int  n_chk = 0, n_bad = 0;
  bit  finished = 1'b0;

  task automatic ceq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [7:0] i);
    return exp_wr[i] ? exp_mem[i] : seed_word(i);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit spam);
    logic [AW-1:0] pm;
    logic [DW-1:0] pd, ld_exp;
    pm = mar_m;
    pd = mdr_m;
    ld_exp = exp_read(a[7:0]);
    @(negedge clk);
    ceq("R2 idle before request", 32'(busy_o), 32'd0);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);  // cycle 1
    req = spam; we = 1'b1; addr = ~a; wdata = ~d;
    ceq("R7 busy cycle1", 32'(busy_o), 32'd1);
    ceq("R5 no strobe cycle1", {mem_rd_o, mem_wr_o}, 32'd0);
    ceq(w ? "R4 addr old cycle1" : "R3 addr old cycle1", 32'(mem_addr_o), 32'(pm));
    ceq(w ? "R4 data old cycle1" : "R3 data old cycle1", 32'(mem_wdata_o), 32'(pd));
    @(negedge clk);  // cycle 2
    if (w) begin
      ceq("R4 data staged cycle2", 32'(mem_wdata_o), 32'(d));
      ceq("R4 addr still old cycle2", 32'(mem_addr_o), 32'(pm));
      ceq("R9 rdata shows store word", 32'(rdata_o), 32'(d));
      ceq("R5 no strobe cycle2", {mem_rd_o, mem_wr_o}, 32'd0);
    end else begin
      ceq("R3 addr staged cycle2", 32'(mem_addr_o), 32'(a));
      ceq("R3 read strobe cycle2", {mem_rd_o, mem_wr_o}, 32'b10);
    end
    @(negedge clk);  // cycle 3
    ceq("R6 no done cycle3", 32'(done_o), 32'd0);
    if (w) begin
      ceq("R4 addr staged cycle3", 32'(mem_addr_o), 32'(a));
      ceq("R4 data held cycle3", 32'(mem_wdata_o), 32'(d));
      ceq("R4 write strobe cycle3", {mem_rd_o, mem_wr_o}, 32'b01);
    end else begin
      ceq("R5 read strobe single", {mem_rd_o, mem_wr_o}, 32'd0);
    end
    @(negedge clk);  // cycle 4: done, conflicting request still high if spam
    ceq("R6 done cycle4", 32'(done_o), 32'd1);
    ceq("R7 busy in done cycle", 32'(busy_o), 32'd1);
    ceq("R5 no strobe cycle4", {mem_rd_o, mem_wr_o}, 32'd0);
    if (w) ceq("R9 rdata after store", 32'(rdata_o), 32'(d));
    else   ceq("R8 load word captured", 32'(rdata_o), 32'(ld_exp));
    @(negedge clk);  // cycle 5
    req = 1'b0;
    ceq("R6 done single", 32'(done_o), 32'd0);
    ceq("R7 idle cycle5", 32'(busy_o), 32'd0);
    mar_m = a;
    if (w) begin
      mdr_m = d;
      exp_mem[a[7:0]] = d;
      exp_wr[a[7:0]]  = 1'b1;
    end else begin
      mdr_m = ld_exp;
    end
    if (spam) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        ceq("R2 dropped request no strobe", {mem_rd_o, mem_wr_o, busy_o}, 32'd0);
        ceq("R2 dropped request addr kept", 32'(mem_addr_o), 32'(a));
        ceq("R2 dropped request data kept", 32'(mem_wdata_o), 32'(mdr_m));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    ceq("R1 reset addr", 32'(mem_addr_o), 32'd0);
    ceq("R1 reset data", 32'(rdata_o), 32'd0);
    ceq("R1 reset strobes", {mem_rd_o, mem_wr_o, busy_o, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    ceq("R1 after release", {mem_rd_o, mem_wr_o, busy_o, done_o}, 32'd0);
    ceq("R1 after release regs", {mem_addr_o, mem_wdata_o}, 32'd0);

    // loads of untouched words, high address byte varied
    for (int i = 0; i < 256; i++)
      access(1'b0, {8'(i) ^ 8'h3c, 8'(i)}, '0, 1'b0);
    // stores over every index
    for (int i = 0; i < 256; i++)
      access(1'b1, {8'(i) ^ 8'ha5, 8'(i)}, ~seed_word(8'(i)) + DW'(i), 1'b0);
    // read back
    for (int i = 0; i < 256; i++)
      access(1'b0, {8'(255 - i), 8'(i)}, '0, 1'b0);

    // R2: conflicting store held through busy and done cycles must be dropped
    access(1'b0, 16'h1207, '0, 1'b1);    // spam targets ~addr = 16'hedf8
    access(1'b1, 16'h0040, 16'hbeef, 1'b1);
    access(1'b0, 16'hedf8, '0, 1'b0);    // must be unmodified by the dropped store
    ceq("R2 dropped store left memory", 32'(rdata_o), 32'(exp_read(8'hf8)));
    access(1'b0, 16'hffbf, '0, 1'b0);
    ceq("R2 dropped store left memory 2", 32'(rdata_o), 32'(exp_read(8'hbf)));
    // back-to-back store then load of the same word
    access(1'b1, 16'h8001, 16'h0000, 1'b0);
    access(1'b0, 16'h8001, '0, 1'b0);
    ceq("R8 zero word readback", 32'(rdata_o), 32'd0);
    access(1'b1, 16'hffff, 16'hffff, 1'b0);
    access(1'b0, 16'h00ff, '0, 1'b0);
    ceq("R8 all-ones readback", 32'(rdata_o), 32'hffff);

    finish_run();
  end

endmodule